// File: doc/BRIEF.md
# Serial Control-Register Slave for an Audio Decoder

This block is the control port of a television sound decoder. A host on a two-wire serial bus writes a small bank of byte-wide control registers and reads back one status byte. The block samples the bus clock and data lines with its own system clock. It finds start and stop events and checks the device address. It acknowledges each byte by pulling the data line low through an output-enable pin, since the bus is open-drain. Each register is presented as a parallel control bus to the analog processing around it.

A write frame carries the device address, a sub-address and one or more data bytes. Bit 7 of the sub-address selects how a burst of data bytes is placed. When bit 7 is 0, each data byte goes to the next register index. When bit 7 is 1, every data byte goes to the same register. A read frame has no sub-address. It returns one byte that carries the pilot-tone and second-audio-carrier detector flags.

Top module: `audio_ctl_slave`

## Requirements
- R1: While reset is held, every byte of `ctlRegs` reads 0x00 and `sdaOe` is 0, so the data line is released.
- R2: After a start, the address byte 0xB6 is acknowledged. In that frame, the sub-address byte and every data byte are acknowledged too. An acknowledge means `sdaOe` is 1 during the ninth SCL high phase. `sdaOe` never changes while SCL is high.
- R3: An address byte other than 0xB6 or 0xB7 gets no acknowledge. The bytes that follow it, up to the next start, change no register and are not acknowledged.
- R4: With sub-address bit 7 = 0, sub-address bits 6:0 give the first register index. Each further data byte in the same frame goes to the next index. Byte n of `ctlRegs` (bits 8n+7:8n) is register index n, and at most one register changes per system clock.
- R5: In the increment mode, the index after 7 is 0.
- R6: Only indices 0, 1, 2, 5 and 6 hold data. A data byte sent to any other index is still acknowledged, but no register changes. Bytes 3, 4 and 7 of `ctlRegs` always read 0x00.
- R7: With sub-address bit 7 = 1, every data byte of the frame overwrites the register at index bits 6:0. All other registers keep their values.
- R8: The address byte 0xB7 is acknowledged. The slave then sends one byte MSB first: D7 = `pilotDet`, D6 = `sapDet`, D5..D0 = 0. After the host's acknowledge bit, the slave leaves the line released.
- R9: `agcCurve` equals bits 7:6 of register 0 and selects one of four AGC transfer curves.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 20 times the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | 1 pulls the data line low |
| pilotDet | input | 1 | Stereo pilot detector flag |
| sapDet | input | 1 | Second-audio carrier detector flag |
| ctlRegs | output | 64 | Register bank; byte n is register index n |
| agcCurve | output | 2 | AGC curve select taken from register 0 |

## Verification
Single-byte writes to two registers first set a known base state. Bursts in increment mode follow: one starts at index 0 and one starts at index 5. The run from index 5 crosses the unused index 7 and wraps to index 0, so a missing wrap or a stored discarded byte shows up in a different byte lane. A burst in overwrite mode to the same region separates the two modes, because only the last byte may land and its neighbour must stay untouched. A burst to an unused index, and a frame with a wrong address, tell apart "acknowledged but dropped" from "not acknowledged at all". Reads under all four flag combinations check the bit placement of the status byte.

// File: rtl/audio_ctl_pkg.sv
package audio_ctl_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_SUB,
    PH_DATA
  } phase_t;

  // strobes from bus control to register datapath
  typedef struct packed {
    logic              subLoad;
    logic              dataWr;
    logic [BYTE_W-1:0] rxByte;
  } ctlStrobe_t;
endpackage

// File: rtl/audio_ctl_sync.sv
module audio_ctl_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stageQ[s] <= '1;
    end else begin
      stageQ[0] <= din;
      for (int s = 1; s < STAGES; s++) stageQ[s] <= stageQ[s-1];
    end
  end

  assign dout = stageQ[STAGES-1];
endmodule

// File: rtl/audio_ctl_fsm.sv
module audio_ctl_fsm
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h5B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclS,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] statusByte,
  output logic              sdaOe,
  output ctlStrobe_t        strobe
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  busState_t         state;
  phase_t            phase;
  logic [CNT_W-1:0]  bitCnt;
  logic              full;
  logic              rdMode;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] txShift;
  logic              oeQ;
  logic              subLoadQ;
  logic              dataWrQ;
  logic              sclPrev;
  logic              sdaPrev;

  logic startEv, stopEv, sclRise, sclFall;
  assign startEv = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopEv  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise = sclS && !sclPrev;
  assign sclFall = !sclS && sclPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      bitCnt   <= '0;
      full     <= 1'b0;
      rdMode   <= 1'b0;
      shiftReg <= '0;
      txShift  <= '0;
      oeQ      <= 1'b0;
      subLoadQ <= 1'b0;
      dataWrQ  <= 1'b0;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
    end else begin
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
      subLoadQ <= 1'b0;
      dataWrQ  <= 1'b0;
      if (startEv) begin
        state  <= ST_RX;
        phase  <= PH_ADDR;
        bitCnt <= '0;
        full   <= 1'b0;
        rdMode <= 1'b0;
        oeQ    <= 1'b0;
      end else if (stopEv) begin
        state <= ST_IDLE;
        oeQ   <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && !full) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sdaS};
              bitCnt   <= bitCnt + 1'b1;
              if (bitCnt == LAST_BIT) full <= 1'b1;
            end else if (sclFall && full) begin
              full <= 1'b0;
              case (phase)
                PH_ADDR: begin
                  if (shiftReg[BYTE_W-1:1] == DEV_ADDR) begin
                    oeQ    <= 1'b1;
                    state  <= ST_ACK;
                    rdMode <= shiftReg[0];
                    phase  <= PH_SUB;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                PH_SUB: begin
                  oeQ      <= 1'b1;
                  state    <= ST_ACK;
                  subLoadQ <= 1'b1;
                  phase    <= PH_DATA;
                end
                default: begin
                  oeQ     <= 1'b1;
                  state   <= ST_ACK;
                  dataWrQ <= 1'b1;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (rdMode) begin
                txShift <= statusByte;
                oeQ     <= ~statusByte[BYTE_W-1];
                state   <= ST_TX;
              end else begin
                oeQ   <= 1'b0;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                oeQ   <= 1'b0;
                state <= ST_TXACK;
              end else begin
                bitCnt  <= bitCnt + 1'b1;
                txShift <= {txShift[BYTE_W-2:0], 1'b0};
                oeQ     <= ~txShift[BYTE_W-2];
              end
            end
          end
          ST_TXACK: begin
            if (sclRise) state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaOe          = oeQ;
  assign strobe.subLoad = subLoadQ;
  assign strobe.dataWr  = dataWrQ;
  assign strobe.rxByte  = shiftReg;
endmodule

// File: rtl/audio_ctl_regs.sv
module audio_ctl_regs
  import audio_ctl_pkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter logic [NUM_REGS-1:0] IMPL_MASK = 8'b0110_0111
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic                       pilotDet,
  input  logic                       sapDet,
  output logic [NUM_REGS*BYTE_W-1:0] regFlat,
  output logic [BYTE_W-1:0]          statusByte
);
  localparam int IDX_W = BYTE_W - 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] idx;
  logic             renew;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      renew <= 1'b0;
    end else if (strobe.subLoad) begin
      idx   <= strobe.rxByte[IDX_W-1:0];
      renew <= strobe.rxByte[BYTE_W-1];
    end else if (strobe.dataWr && !renew) begin
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    if (IMPL_MASK[g]) begin : gImpl
      logic [BYTE_W-1:0] r;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) r <= '0;
        else if (strobe.dataWr && idx == IDX_W'(g)) r <= strobe.rxByte;
      end
      assign regFlat[g*BYTE_W +: BYTE_W] = r;
    end else begin : gVoid
      assign regFlat[g*BYTE_W +: BYTE_W] = '0;
    end
  end

  assign statusByte = {pilotDet, sapDet, {(BYTE_W-2){1'b0}}};
endmodule

// File: rtl/audio_ctl_slave.sv
module audio_ctl_slave
  import audio_ctl_pkg::*;
#(
  parameter logic [6:0]          DEV_ADDR    = 7'h5B,
  parameter int                  SYNC_STAGES = 2,
  parameter int                  NUM_REGS    = 8,
  parameter logic [NUM_REGS-1:0] IMPL_MASK   = 8'b0110_0111
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclIn,
  input  logic                       sdaIn,
  output logic                       sdaOe,
  input  logic                       pilotDet,
  input  logic                       sapDet,
  output logic [NUM_REGS*BYTE_W-1:0] ctlRegs,
  output logic [1:0]                 agcCurve
);
  logic [1:0]        busS;
  ctlStrobe_t        strobe;
  logic [BYTE_W-1:0] statusByte;

  audio_ctl_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) uSync (
    .clk(clk), .rstN(rstN), .din({sclIn, sdaIn}), .dout(busS)
  );

  audio_ctl_fsm #(.DEV_ADDR(DEV_ADDR)) uFsm (
    .clk(clk), .rstN(rstN), .sclS(busS[1]), .sdaS(busS[0]),
    .statusByte(statusByte), .sdaOe(sdaOe), .strobe(strobe)
  );

  audio_ctl_regs #(.NUM_REGS(NUM_REGS), .IMPL_MASK(IMPL_MASK)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pilotDet(pilotDet),
    .sapDet(sapDet), .regFlat(ctlRegs), .statusByte(statusByte)
  );

  assign agcCurve = ctlRegs[BYTE_W-1 -: 2];
endmodule

// File: rtl/audio_ctl_chk.sv
module audio_ctl_chk #(
  parameter int NUM_REGS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclIn,
  input logic                  sdaOe,
  input logic [NUM_REGS*8-1:0] ctlRegs
);
  logic                  seenRst = 1'b0;
  logic [NUM_REGS*8-1:0] prevRegs;
  logic [NUM_REGS-1:0]   byteChg;

  always_ff @(posedge clk) begin
    prevRegs <= ctlRegs;
    if (!rstN) begin
      if (seenRst) begin
        // R1
        reset_zero_chk: assert (ctlRegs == '0 && !sdaOe)
          else $error("reset state not clear");
      end
      seenRst <= 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++)
      byteChg[i] = (ctlRegs[i*8 +: 8] != prevRegs[i*8 +: 8]);
  end

  // R2
  oe_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaOe));

  // R4
  one_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(byteChg) <= 1);

  // R4
  write_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteChg != '0) |-> !sclIn);
endmodule

bind audio_ctl_slave audio_ctl_chk #(.NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe), .ctlRegs(ctlRegs)
);

// File: tb/audio_ctl_slave_test.sv
module audio_ctl_slave_test;
  localparam time Q = 40ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        pilotDet = 1'b0;
  logic        sapDet = 1'b0;
  logic        sdaOe;
  logic [63:0] ctlRegs;
  logic [1:0]  agcCurve;
  logic        sdaBus;

  assign sdaBus = sdaM & ~sdaOe;

  audio_ctl_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .pilotDet(pilotDet), .sapDet(sapDet), .ctlRegs(ctlRegs), .agcCurve(agcCurve)
  );

  always #2ns clk = ~clk;

  int    nChecks = 0;
  int    nFails = 0;
  int    ackMask;
  int    rdVal;
  int    qKind[$];
  int    qExp[$];
  string qTag[$];
  logic [7:0] model [8];
  event  checkNow;

  // kinds: 0..7 register byte, 8 sdaOe, 9 agcCurve, 10 ack mask, 11 read byte
  function automatic int obs(input int kind);
    if (kind < 8) return int'(ctlRegs[kind*8 +: 8]);
    if (kind == 8) return int'(sdaOe);
    if (kind == 9) return int'(agcCurve);
    if (kind == 10) return ackMask;
    return rdVal;
  endfunction

  task automatic expect_item(input int kind, input int val, input string tag);
    qKind.push_back(kind); qExp.push_back(val); qTag.push_back(tag);
  endtask

  task automatic expect_all_regs(input string tag);
    for (int i = 0; i < 8; i++) expect_item(i, int'(model[i]), tag);
  endtask

  initial begin
    forever begin
      @(checkNow);
      while (qKind.size() > 0) begin
        int k, e, a;
        string t;
        k = qKind.pop_front(); e = qExp.pop_front(); t = qTag.pop_front();
        a = obs(k);
        nChecks++;
        if (a !== e) begin
          nFails++;
          $display("FAIL %s kind %0d actual %0h expected %0h", t, k, a, e);
        end
      end
    end
  end

  task automatic bus_bit(input logic b, output logic seen);
    sdaM = b; #Q;
    sclM = 1'b1; #(Q/2);
    seen = sdaBus; #(Q/2);
    sclM = 1'b0; #Q;
  endtask

  task automatic bus_start();
    sdaM = 1'b1; #Q; sclM = 1'b1; #Q; sdaM = 1'b0; #Q; sclM = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sdaM = 1'b0; #Q; sclM = 1'b1; #Q; sdaM = 1'b1; #Q;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
    bus_bit(1'b1, s);
    ack = !s;
  endtask

  task automatic wr_frame(input logic [7:0] bytes[$]);
    logic a;
    ackMask = 0;
    bus_start();
    for (int i = 0; i < bytes.size(); i++) begin
      send_byte(bytes[i], a);
      if (a) ackMask |= (1 << i);
    end
    bus_stop();
  endtask

  task automatic rd_frame();
    logic a, s;
    logic [7:0] v;
    ackMask = 0;
    bus_start();
    send_byte(8'hB7, a);
    if (a) ackMask = 1;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, s);
      v[i] = s;
    end
    bus_bit(1'b1, s);
    bus_stop();
    rdVal = int'(v);
  endtask

  // expected placement from R4..R7
  task automatic model_write(input logic [7:0] sub, input logic [7:0] d[$]);
    int idx;
    idx = int'(sub[6:0]);
    for (int i = 0; i < d.size(); i++) begin
      if (idx == 0 || idx == 1 || idx == 2 || idx == 5 || idx == 6) model[idx] = d[i];
      if (!sub[7]) idx = (idx == 7) ? 0 : idx + 1;
    end
  endtask

  task automatic do_write(input logic [7:0] sub, input logic [7:0] d[$], input string tag);
    logic [7:0] fr[$];
    fr.push_back(8'hB6); fr.push_back(sub);
    foreach (d[i]) fr.push_back(d[i]);
    wr_frame(fr);
    model_write(sub, d);
    expect_item(10, (1 << fr.size()) - 1, {tag, " ack"});
    expect_all_regs(tag);
    -> checkNow; #Q;
  endtask

  task automatic do_read(input logic p, input logic s, input string tag);
    pilotDet = p; sapDet = s;
    rd_frame();
    expect_item(10, 1, {tag, " ack"});
    expect_item(11, {p, s, 6'b0}, tag);
    expect_item(8, 0, {tag, " released"});
    -> checkNow; #Q;
  endtask

  logic done = 1'b0;

  initial begin
    #(800000ns);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'h00;
    #1ns;
    #100ns;
    expect_all_regs("R1 reset");
    expect_item(8, 0, "R1 sda released");
    -> checkNow;
    #20ns;
    rstN = 1'b1;
    #Q;

    do_write(8'h06, '{8'h04}, "R2 single write idx6");
    do_write(8'h02, '{8'h00}, "R2 single write idx2");
    do_write(8'h00, '{8'hA1, 8'hB2, 8'hC3}, "R4 increment from 0");
    // 5,6,7(dropped),0
    do_write(8'h05, '{8'h55, 8'h66, 8'h77, 8'h88}, "R5 wrap with R6 drop");
    expect_item(9, 2, "R9 agc curve after 0x88"); -> checkNow; #Q;
    do_write(8'h83, '{8'h12, 8'h34}, "R6 unused index acked");
    do_write(8'h04, '{8'h9A, 8'hBC}, "R6 increment 4 to 5");
    do_write(8'h81, '{8'h11, 8'h22, 8'h33}, "R7 overwrite idx1");
    do_write(8'h80, '{8'h40}, "R7 single overwrite idx0");
    expect_item(9, 1, "R9 agc curve after 0x40"); -> checkNow; #Q;

    wr_frame('{8'hB4, 8'h01, 8'hEE, 8'hEF});
    expect_item(10, 0, "R3 no ack for wrong address");
    expect_all_regs("R3 wrong address no change");
    expect_item(8, 0, "R3 line released");
    -> checkNow; #Q;

    do_write(8'h01, '{8'h5A}, "R3 recovery after mismatch");

    do_read(1'b1, 1'b0, "R8 pilot only");
    do_read(1'b0, 1'b1, "R8 sap only");
    do_read(1'b1, 1'b1, "R8 both flags");
    do_read(1'b0, 1'b0, "R8 no flags");
    do_write(8'h86, '{8'h01, 8'h02}, "R7 write after read");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule